// File: doc/BRIEF.md
# CAN Transmit Data-Consistency Guard

This block sits between a CAN controller's frame serializer and its transmit pin and keeps corrupt data off the bus. It watches two data-error sources: an ECC error reported on transmit data, and an underflow of the transmit assembly buffer. An underflow occurs when the serializer asks for the next data byte and the buffer has no valid byte to give. If either error shows up as a frame is about to start, the start is refused. If it shows up while a frame is on the wire, the frame is aborted in the same cycle and the pin goes recessive.

After any data error the guard locks into an error state. The controller drops into a degraded mode, and a configuration input selects which one: listen-only or restricted operation. In that state every transmit request is withheld from the arbiter and the pin is held high, but the receive path stays enabled. The shared system-error flag is raised with its interrupt code. Clearing the flag does not unlock the transmitter. Only an explicit mode-change request from the host does that.

Top module: `can_tx_guard`

## Requirements
- R1: When `frame_start_i` is high in a cycle with a data error (`ecc_err_i` high, or an underflow as in R3), `tx_start_o` is low in that cycle.
- R2: When a data error occurs while `frame_active_i` is high and the guard is not yet locked, `tx_abort_o` is high and `tx_pin_o` is 1 in that same cycle.
- R3: An underflow is `byte_req_i` high while `buf_valid_i` is low. A data error counts only when `frame_start_i` or `frame_active_i` is high; outside a frame it has no effect on mode, flag or pin.
- R4: One clock after a counted data error, `mode_o` holds 3'd7 (restricted) if `sel_listen_i` was 0, or 3'd3 (listen-only) if it was 1. Normal mode is 3'd0, and the reset value is normal.
- R5: While locked, and in the cycle of a counted error, `tx_pin_o` is 1 whatever `ser_tx_i` is.
- R6: `tx_req_o` is all zero, and `tx_start_o` is low, while locked, in the cycle of a counted error, or whenever `mode_o` is not normal.
- R7: `rx_enable_o` is 1 in every mode except configuration (3'd4), including the error state.
- R8: One clock after a counted error, `serr_flag_o` is 1 and `icode_o` is 7'h45. While the flag is 0, `icode_o` is 7'h40 (no interrupt).
- R9: `flag_clr_i` clears the flag one clock later. A counted error in the same cycle wins, and the flag stays set.
- R10: The lock persists until a host request (`mode_req_valid_i`) is taken, which loads `mode_req_i` into `mode_o` and unlocks. Clearing the flag does not unlock. A counted error wins over a simultaneous host request.
- R11: In normal mode with no error, `tx_pin_o` follows `ser_tx_i`, `tx_start_o` follows `frame_start_i`, and `tx_req_o` equals `tx_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req_i | input | NUM_TXQ | Pending transmit requests from the host queues |
| tx_req_o | output | NUM_TXQ | Requests passed on to the transmit arbiter |
| frame_start_i | input | 1 | Serializer wants to begin a frame this cycle |
| frame_active_i | input | 1 | Serializer is sending a frame |
| byte_req_i | input | 1 | Serializer asks for the next data byte |
| buf_valid_i | input | 1 | Assembly buffer holds a valid byte |
| ecc_err_i | input | 1 | ECC error on transmit data |
| ser_tx_i | input | 1 | Bit from the serializer |
| tx_start_o | output | 1 | Frame start granted |
| tx_abort_o | output | 1 | Abort the frame in progress |
| tx_pin_o | output | 1 | Transmit pin, 1 = recessive |
| sel_listen_i | input | 1 | Degraded mode choice: 1 listen-only, 0 restricted |
| mode_req_valid_i | input | 1 | Host mode-change request strobe |
| mode_req_i | input | MODE_W | Requested mode |
| mode_o | output | MODE_W | Current operating mode |
| rx_enable_o | output | 1 | Receive path enabled |
| flag_clr_i | input | 1 | Host writes zero to the system-error flag |
| serr_flag_o | output | 1 | System-error flag |
| icode_o | output | ICODE_W | Interrupt code |

## Verification
The assertions assume the serializer keeps `frame_start_i` and `frame_active_i` coherent. They also assume that `byte_req_i` is meaningful only inside a frame, and that the host raises `mode_req_valid_i` for single-cycle strobes. The stimulus changes all inputs only at the falling clock edge. It raises byte requests outside a frame only to show that they are ignored. It issues mode requests in the same cycle as an error only in the one case that tests the priority between them.

// File: rtl/can_txg_pkg.sv
// Package: shared widths, mode encodings and interrupt codes for the
// transmit data-consistency guard. Assumes a 3-bit mode field.
package can_txg_pkg;
    localparam int MODE_W  = 3;
    localparam int ICODE_W = 7;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL   = 3'd0,
        MODE_LISTEN   = 3'd3,
        MODE_CONFIG   = 3'd4,
        MODE_RESTRICT = 3'd7
    } txg_mode_e;

    localparam logic [ICODE_W-1:0] ICODE_SERR = 7'h45;
    localparam logic [ICODE_W-1:0] ICODE_NONE = 7'h40;
endpackage

// File: rtl/txg_fault_detect.sv
// Fault detector: classifies underflow and ECC errors and qualifies them
// with frame context. Purely combinational.
// Assumes: byte_req/buf_valid are only meaningful inside a frame.
module txg_fault_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start_i,
    input  logic frame_active_i,
    input  logic byte_req_i,
    input  logic buf_valid_i,
    input  logic ecc_err_i,
    input  logic locked_i,
    output logic data_err_o,
    output logic err_evt_o,
    output logic mid_abort_o
);
    logic underflow;
    logic in_frame;

    // Classify raw data errors and qualify them with frame context.
    always_comb begin
        underflow   = byte_req_i & ~buf_valid_i;
        in_frame    = frame_start_i | frame_active_i;
        data_err_o  = ecc_err_i | underflow;
        err_evt_o   = data_err_o & in_frame;
        mid_abort_o = data_err_o & frame_active_i & ~locked_i;
    end

    // R3
    outside_frame_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && !frame_active_i) |-> !err_evt_o);
    // R2
    abort_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_abort_o |-> (frame_active_i && (ecc_err_i || (byte_req_i && !buf_valid_i))));
endmodule

// File: rtl/txg_mode_fsm.sv
// Mode controller: holds the operating mode and the error lock. A counted
// data error locks and enters the selected degraded mode. A host request
// unlocks and loads the requested mode. The error wins a tie.
// Assumes: mode_req_valid_i is a single-cycle strobe.
module txg_mode_fsm
    import can_txg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_evt_i,
    input  logic              sel_listen_i,
    input  logic              mode_req_valid_i,
    input  logic [MODE_W-1:0] mode_req_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              locked_o
);
    logic [MODE_W-1:0] mode_q;
    logic              lock_q;
    logic [MODE_W-1:0] err_mode;

    // Pick the degraded mode from the configuration bit.
    always_comb err_mode = sel_listen_i ? MODE_LISTEN : MODE_RESTRICT;

    // Update the mode and lock; the error has priority over the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
            lock_q <= 1'b0;
        end else if (err_evt_i) begin
            mode_q <= err_mode;
            lock_q <= 1'b1;
        end else if (mode_req_valid_i) begin
            mode_q <= mode_req_i;
            lock_q <= 1'b0;
        end
    end

    assign mode_o   = mode_q;
    assign locked_o = lock_q;

    // R4
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i |=> (mode_o == ($past(sel_listen_i) ? MODE_LISTEN : MODE_RESTRICT)));
    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !mode_req_valid_i) |=> locked_o);
endmodule

// File: rtl/txg_serr_flag.sv
// System-error flag: set by a counted data error, cleared by the host
// writing zero. Set wins over clear. Drives the interrupt code.
// Assumes: flag_clr_i is a single-cycle write strobe.
module txg_serr_flag
    import can_txg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_evt_i,
    input  logic               flag_clr_i,
    output logic               flag_o,
    output logic [ICODE_W-1:0] icode_o
);
    logic flag_q;

    // Hold the flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (err_evt_i)  flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // Report the interrupt code for the current flag.
    always_comb icode_o = flag_q ? ICODE_SERR : ICODE_NONE;

    assign flag_o = flag_q;

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i |=> (flag_o && icode_o == 7'h45));
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !err_evt_i) |=> !flag_o);
endmodule

// File: rtl/can_tx_guard.sv
// Top: transmit data-consistency guard. Blocks or aborts frames on data
// errors, forces the pin recessive, gates transmit requests and keeps the
// receive path enabled outside configuration mode.
// Assumes: the serializer keeps frame_start_i and frame_active_i coherent.
module can_tx_guard
    import can_txg_pkg::*;
#(
    parameter int NUM_TXQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TXQ-1:0] tx_req_i,
    output logic [NUM_TXQ-1:0] tx_req_o,
    input  logic               frame_start_i,
    input  logic               frame_active_i,
    input  logic               byte_req_i,
    input  logic               buf_valid_i,
    input  logic               ecc_err_i,
    input  logic               ser_tx_i,
    output logic               tx_start_o,
    output logic               tx_abort_o,
    output logic               tx_pin_o,
    input  logic               sel_listen_i,
    input  logic               mode_req_valid_i,
    input  logic [MODE_W-1:0]  mode_req_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic               rx_enable_o,
    input  logic               flag_clr_i,
    output logic               serr_flag_o,
    output logic [ICODE_W-1:0] icode_o
);
    logic data_err;
    logic err_evt;
    logic mid_abort;
    logic locked;
    logic blocked;
    logic silence;

    txg_fault_detect u_detect (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start_i  (frame_start_i),
        .frame_active_i (frame_active_i),
        .byte_req_i     (byte_req_i),
        .buf_valid_i    (buf_valid_i),
        .ecc_err_i      (ecc_err_i),
        .locked_i       (locked),
        .data_err_o     (data_err),
        .err_evt_o      (err_evt),
        .mid_abort_o    (mid_abort)
    );

    txg_mode_fsm u_mode (
        .clk              (clk),
        .rst_n            (rst_n),
        .err_evt_i        (err_evt),
        .sel_listen_i     (sel_listen_i),
        .mode_req_valid_i (mode_req_valid_i),
        .mode_req_i       (mode_req_i),
        .mode_o           (mode_o),
        .locked_o         (locked)
    );

    txg_serr_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt_i  (err_evt),
        .flag_clr_i (flag_clr_i),
        .flag_o     (serr_flag_o),
        .icode_o    (icode_o)
    );

    // Decide whether the transmit side is silenced and whether it is blocked.
    always_comb begin
        silence = locked | err_evt;
        blocked = silence | (mode_o != MODE_NORMAL);
    end

    // Gate each request queue independently.
    for (genvar q = 0; q < NUM_TXQ; q++) begin : g_req_gate
        assign tx_req_o[q] = tx_req_i[q] & ~blocked;
    end

    // Drive the start grant, the abort, the pin and the receive enable.
    always_comb begin
        tx_start_o  = frame_start_i & ~blocked;
        tx_abort_o  = mid_abort;
        tx_pin_o    = silence ? 1'b1 : ser_tx_i;
        rx_enable_o = (mode_o != MODE_CONFIG);
    end

    // R1
    no_start_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && data_err) |-> !tx_start_o);
    // R5
    pin_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked || tx_abort_o) |-> tx_pin_o);
    // R6
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (tx_req_o == '0 && !tx_start_o));
    // R7
    rx_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> rx_enable_o);
endmodule

// File: tb/test_can_tx_guard.sv
`timescale 1ns/100ps
module test_can_tx_guard;
    localparam int NQ = 8;

    typedef struct {
        string     tag;
        logic [NQ-1:0] req;
        logic      start, abort, pin, rxen, flag;
        logic [2:0] mode;
        logic [6:0] icode;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NQ-1:0] tx_req_i = '0;
    logic [NQ-1:0] tx_req_o;
    logic frame_start_i = 0, frame_active_i = 0, byte_req_i = 0, buf_valid_i = 0;
    logic ecc_err_i = 0, ser_tx_i = 1, sel_listen_i = 0, mode_req_valid_i = 0, flag_clr_i = 0;
    logic [2:0] mode_req_i = '0;
    logic tx_start_o, tx_abort_o, tx_pin_o, rx_enable_o, serr_flag_o;
    logic [2:0] mode_o;
    logic [6:0] icode_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    exp_t sb[$];

    // bench model of the requirements
    bit m_err = 0, m_flag = 0;
    logic [2:0] m_mode = 3'd0;

    always #2 clk = ~clk;

    can_tx_guard #(.NUM_TXQ(NQ)) i_can_tx_guard (
        .clk(clk), .rst_n(rst_n), .tx_req_i(tx_req_i), .tx_req_o(tx_req_o),
        .frame_start_i(frame_start_i), .frame_active_i(frame_active_i),
        .byte_req_i(byte_req_i), .buf_valid_i(buf_valid_i), .ecc_err_i(ecc_err_i),
        .ser_tx_i(ser_tx_i), .tx_start_o(tx_start_o), .tx_abort_o(tx_abort_o),
        .tx_pin_o(tx_pin_o), .sel_listen_i(sel_listen_i),
        .mode_req_valid_i(mode_req_valid_i), .mode_req_i(mode_req_i),
        .mode_o(mode_o), .rx_enable_o(rx_enable_o), .flag_clr_i(flag_clr_i),
        .serr_flag_o(serr_flag_o), .icode_o(icode_o)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: just before each rising edge, pop and compare.
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.tag, "tx_req_o", int'(tx_req_o), int'(e.req));
            cmp(e.tag, "tx_start_o", int'(tx_start_o), int'(e.start));
            cmp(e.tag, "tx_abort_o", int'(tx_abort_o), int'(e.abort));
            cmp(e.tag, "tx_pin_o", int'(tx_pin_o), int'(e.pin));
            cmp(e.tag, "mode_o", int'(mode_o), int'(e.mode));
            cmp(e.tag, "rx_enable_o", int'(rx_enable_o), int'(e.rxen));
            cmp(e.tag, "serr_flag_o", int'(serr_flag_o), int'(e.flag));
            cmp(e.tag, "icode_o", int'(icode_o), int'(e.icode));
        end
    end

    // Driver: apply one cycle of stimulus, push the expectation, advance the model.
    task automatic step(string tag, logic [NQ-1:0] req, bit fs, bit fa, bit br, bit bv,
                        bit ecc, bit ser, bit sel, bit mv, logic [2:0] mr, bit clr);
        exp_t e;
        bit derr, evt, blk;
        @(negedge clk);
        tx_req_i = req; frame_start_i = fs; frame_active_i = fa; byte_req_i = br;
        buf_valid_i = bv; ecc_err_i = ecc; ser_tx_i = ser; sel_listen_i = sel;
        mode_req_valid_i = mv; mode_req_i = mr; flag_clr_i = clr;
        derr = ecc | (br & ~bv);
        evt  = derr & (fs | fa);
        blk  = m_err | evt | (m_mode != 3'd0);
        e.tag   = tag;
        e.req   = blk ? '0 : req;
        e.start = fs & ~blk;
        e.abort = evt & fa & ~m_err;
        e.pin   = (m_err | evt) ? 1'b1 : ser;
        e.mode  = m_mode;
        e.rxen  = (m_mode != 3'd4);
        e.flag  = m_flag;
        e.icode = m_flag ? 7'h45 : 7'h40;
        sb.push_back(e);
        if (evt) begin
            m_err = 1; m_mode = sel ? 3'd3 : 3'd7;
        end else if (mv) begin
            m_err = 0; m_mode = mr;
        end
        if (evt) m_flag = 1;
        else if (clr) m_flag = 0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //          tag           req    fs fa br bv ec sr sl mv mr  clr
        step("R11_reset",   8'h00, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R11_start",   8'hA5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R11_bytes",   8'h3C, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R2_underrun", 8'h3C, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R4_R8_rstr",  8'hFF, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R5_R6_lock",  8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10_clrkeep", 8'h0F, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10_exit",    8'h0F, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R11_back",    8'h81, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R1_prestart", 8'h81, 1, 0, 0, 1, 1, 0, 1, 0, 0, 0);
        step("R4_listen",   8'h81, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R9_setwins",  8'h00, 0, 1, 0, 0, 1, 0, 1, 0, 0, 1);
        step("R10_errwins", 8'h00, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0);
        step("R7_rxkept",   8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10_exit2",   8'h00, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R3_outside",  8'h55, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        step("R3_after",    8'h55, 0, 0, 0, 0, 0, 1, 0, 1, 3'd4, 0);
        step("R7_config",   8'h55, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6_cfgblock", 8'h55, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R11_final",   8'h55, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule